// File: doc/BRIEF.md
# Bit-serial linear constraint evaluator

This block decides, one bit at a time, whether the linear relation `C1*x + C2*y + K0 REL z` holds over two's-complement bit-vectors. The three variables `x`, `y` and `z` arrive together, least significant bit first, one bit of each per accepted beat. After every accepted beat the block reports whether the relation holds when all operands are truncated to the number of bits received so far. The coefficients `C1` and `C2`, the additive constant `K0` and the relation `REL` are fixed when the block is elaborated.

Multiplication by a coefficient is a set of one-beat delays of the variable stream added through a chain of serial adders. A negative coefficient adds a serial two's-complement negation stage. The additive constant is produced from a beat counter. The verdict is masked until the stream is wide enough to hold every constant, and it is also masked by a single-bit enable that is captured at the start of each stream.

Input beats use a valid/ready pair. The block never applies back-pressure: `in_ready` is always high, and a beat is accepted on every cycle with `in_valid` high. A cycle with `in_valid` low is a bubble that changes nothing. The result side has no ready. `res_valid` pulses for one cycle per accepted beat, and `res_sat` holds its value until the next accepted beat.

Top module: `lincon_serial_eval`

## Requirements
- R1: The result for an accepted beat appears on the next clock edge: `res_valid` is high in exactly the cycle after each beat with `in_valid` high.
- R2: After n beats of a stream, the left side is `(C1*X + C2*Y + K0) mod 2^n`, where X, Y and Z are the first n bits received. A negative coefficient subtracts in two's complement.
- R3: Bit i of the additive constant is bit i of `K0` for i < `CW` and the sign bit of `K0` for every later beat. This makes the constant correct at every width.
- R4: `REL` selects the relation between the left side L and Z at width n. The encodings are EQ=0, NE=1, ULT=2, ULE=3, UGT=4, UGE=5, SLT=6, SLE=7, SGT=8 and SGE=9. The signed relations read bit n-1 as the sign.
- R5: `res_sat` is 0 while n < KMIN. KMIN is the largest two's-complement width needed by `C1`, `C2` or `K0`; it is 4 for the defaults 3, -2 and -6.
- R6: `en_bit` is captured on the beat that carries `start` and is held for the rest of the stream. `res_sat` can only be 1 when the captured value is 1, whatever `en_bit` does on later beats.
- R7: A beat with `start` high begins a new stream as bit 0. Nothing from earlier beats affects the new verdict: carries, delays, the comparison state and the beat count are all cleared.
- R8: A cycle with `in_valid` low changes no state. `res_valid` is low in the following cycle, and `res_sat` keeps its value.
- R9: `in_ready` is 1 in every cycle, including during reset.
- R10: During reset and in the cycle after it, `res_valid` and `res_sat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Marks the beat that carries bit 0 of a new stream |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat ready, always 1 |
| x_bit | input | 1 | Current bit of variable x |
| y_bit | input | 1 | Current bit of variable y |
| z_bit | input | 1 | Current bit of variable z |
| en_bit | input | 1 | Enable literal, captured on the start beat |
| res_valid | output | 1 | One-cycle pulse after each accepted beat |
| res_sat | output | 1 | Guarded verdict for the bits received so far |

## Verification
The bench builds three copies of the block. All three use `CW`=4, `C1`=3, `C2`=-2 and `K0`=-6; they differ only in the relation, which is SLE, EQ and UGT. The negative coefficient and the negative constant exercise the negation stage and the sign-extended constant beyond bit 3. KMIN is 4, so the guard covers three beats on which the unguarded relation can already be true. Streams of up to 16 bits let the signed and unsigned verdicts diverge, and they let carries ripple through several delay stages.

// File: rtl/lincon_pkg.sv
package lincon_pkg;

  typedef enum logic [3:0] {
    REL_EQ  = 4'd0, REL_NE  = 4'd1,
    REL_ULT = 4'd2, REL_ULE = 4'd3,
    REL_UGT = 4'd4, REL_UGE = 4'd5,
    REL_SLT = 4'd6, REL_SLE = 4'd7,
    REL_SGT = 4'd8, REL_SGE = 4'd9
  } rel_e;

  // smallest two's-complement width holding v
  function automatic int min_sbits(input int v);
    int w;
    w = 32;
    for (int n = 31; n >= 1; n--) begin
      if (longint'(v) >= -(64'sd1 <<< (n - 1)) && longint'(v) < (64'sd1 <<< (n - 1)))
        w = n;
    end
    return w;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lincon_sadd.sv
module lincon_sadd #(
  parameter bit CIN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic first,
  input  logic a,
  input  logic b,
  output logic s
);
  logic c_q;
  logic c_in;

  assign c_in = first ? CIN : c_q;
  assign s    = a ^ b ^ c_in;

  always_ff @(posedge clk) begin
    if (!rst_n)    c_q <= 1'b0;
    else if (beat) c_q <= (a & b) | (c_in & (a ^ b));
  end
endmodule

// File: rtl/lincon_cmul.sv
module lincon_cmul #(
  parameter int CW = 4,
  parameter int C  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic first,
  input  logic x,
  output logic p
);
  localparam int            ABSC = (C < 0) ? -C : C;
  localparam logic [CW-1:0] MAG  = ABSC[CW-1:0];

  logic [CW-1:0] xd;   // x delayed by j beats
  logic [CW:0]   acc;  // partial sums

  assign xd[0]  = x;
  assign acc[0] = 1'b0;

  for (genvar j = 1; j < CW; j++) begin : g_dly
    logic d_q;
    always_ff @(posedge clk) begin
      if (!rst_n)    d_q <= 1'b0;
      else if (beat) d_q <= xd[j-1];
    end
    assign xd[j] = first ? 1'b0 : d_q;
  end

  for (genvar j = 0; j < CW; j++) begin : g_add
    lincon_sadd #(.CIN(1'b0)) u_add (
      .clk(clk), .rst_n(rst_n), .beat(beat), .first(first),
      .a(acc[j]), .b(MAG[j] & xd[j]), .s(acc[j+1])
    );
  end

  if (C < 0) begin : g_neg
    lincon_sadd #(.CIN(1'b1)) u_neg (
      .clk(clk), .rst_n(rst_n), .beat(beat), .first(first),
      .a(~acc[CW]), .b(1'b0), .s(p)
    );
  end else begin : g_pos
    assign p = acc[CW];
  end
endmodule

// File: rtl/lincon_scmp.sv
module lincon_scmp #(
  parameter lincon_pkg::rel_e REL = lincon_pkg::REL_SLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic first,
  input  logic a,
  input  logic b,
  output logic hit
);
  import lincon_pkg::*;

  logic eq_q, ult_q;
  logic eq_p, ult_p, diff;
  logic eq_n, ult_n, slt_n;

  assign eq_p  = first ? 1'b1 : eq_q;
  assign ult_p = first ? 1'b0 : ult_q;
  assign diff  = a ^ b;
  assign eq_n  = eq_p & ~diff;
  assign ult_n = diff ? (~a & b) : ult_p;
  assign slt_n = diff ? (a & ~b) : ult_p;

  always_comb begin
    case (REL)
      REL_EQ:  hit = eq_n;
      REL_NE:  hit = ~eq_n;
      REL_ULT: hit = ult_n;
      REL_ULE: hit = ult_n | eq_n;
      REL_UGT: hit = ~(ult_n | eq_n);
      REL_UGE: hit = ~ult_n;
      REL_SLT: hit = slt_n;
      REL_SLE: hit = slt_n | eq_n;
      REL_SGT: hit = ~(slt_n | eq_n);
      default: hit = ~slt_n;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_q  <= 1'b1;
      ult_q <= 1'b0;
    end else if (beat) begin
      eq_q  <= eq_n;
      ult_q <= ult_n;
    end
  end
endmodule

// File: rtl/lincon_serial_eval.sv
module lincon_serial_eval #(
  parameter int               CW  = 4,
  parameter int               C1  = 3,
  parameter int               C2  = -2,
  parameter int               K0  = -6,
  parameter lincon_pkg::rel_e REL = lincon_pkg::REL_SLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  output logic in_ready,
  input  logic x_bit,
  input  logic y_bit,
  input  logic z_bit,
  input  logic en_bit,
  output logic res_valid,
  output logic res_sat
);
  import lincon_pkg::*;

  localparam int            KMIN    = max3(min_sbits(C1), min_sbits(C2), min_sbits(K0));
  localparam int            CNTW    = $clog2(CW + 1);
  localparam logic [CW-1:0] K0_BITS = K0[CW-1:0];

  logic            beat, first;
  logic [CNTW-1:0] cnt_q, idx;
  logic [CW-1:0]   ksh;
  logic            kbit, en_q, en_now, guard_now;
  logic            t1, t2, s12, lhs, hit;
  logic            res_valid_q, res_sat_q;

  assign in_ready = 1'b1;
  assign beat     = in_valid;
  assign first    = in_valid & start;

  // beat index, saturating once the constant is sign-extended
  assign idx = first ? '0 : cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (beat) cnt_q <= (idx == CNTW'(CW)) ? idx : idx + 1'b1;
  end

  // constant bit stream indexed by the beat counter
  assign ksh  = K0_BITS >> idx;
  assign kbit = (idx < CNTW'(CW)) ? ksh[0] : K0_BITS[CW-1];

  // enable literal held from the start beat
  assign en_now = first ? en_bit : en_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    en_q <= 1'b0;
    else if (beat) en_q <= en_now;
  end

  lincon_cmul #(.CW(CW), .C(C1)) u_mul1 (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .x(x_bit), .p(t1)
  );
  lincon_cmul #(.CW(CW), .C(C2)) u_mul2 (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .x(y_bit), .p(t2)
  );
  lincon_sadd #(.CIN(1'b0)) u_sum (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .a(t1), .b(t2), .s(s12)
  );
  lincon_sadd #(.CIN(1'b0)) u_off (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .a(s12), .b(kbit), .s(lhs)
  );
  lincon_scmp #(.REL(REL)) u_cmp (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .a(lhs), .b(z_bit), .hit(hit)
  );

  assign guard_now = (int'(idx) + 1) >= KMIN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_sat_q   <= 1'b0;
    end else begin
      res_valid_q <= beat;
      if (beat) res_sat_q <= guard_now & hit & en_now;
    end
  end

  assign res_valid = res_valid_q;
  assign res_sat   = res_sat_q;
endmodule

// File: rtl/lincon_serial_eval_chk.sv
module lincon_serial_eval_chk #(
  parameter int KMIN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic in_valid,
  input logic en_bit,
  input logic res_valid,
  input logic res_sat
);
  int   beats;
  logic en_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats   <= 0;
      en_seen <= 1'b0;
    end else if (in_valid) begin
      if (start) begin
        beats   <= 1;
        en_seen <= en_bit;
      end else if (beats < KMIN) begin
        beats <= beats + 1;
      end
    end
  end

  p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(res_sat)));

  p_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_sat |-> (beats >= KMIN));

  p_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_sat |-> en_seen);

  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (!res_valid && !res_sat));
endmodule

bind lincon_serial_eval lincon_serial_eval_chk #(.KMIN(KMIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .en_bit(en_bit), .res_valid(res_valid), .res_sat(res_sat)
);

// File: tb/lincon_serial_eval_tb.sv
module lincon_serial_eval_tb;
  import lincon_pkg::*;

  localparam int EC1 = 3, EC2 = -2, EK0 = -6, EKMIN = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, x_bit = 1'b0, y_bit = 1'b0, z_bit = 1'b0, en_bit = 1'b0;
  logic rdy_a, rdy_b, rdy_c;
  logic [2:0] rv, rs;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lincon_serial_eval #(.CW(4), .C1(EC1), .C2(EC2), .K0(EK0), .REL(REL_SLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(rdy_a),
    .x_bit(x_bit), .y_bit(y_bit), .z_bit(z_bit), .en_bit(en_bit),
    .res_valid(rv[0]), .res_sat(rs[0]));
  lincon_serial_eval #(.CW(4), .C1(EC1), .C2(EC2), .K0(EK0), .REL(REL_EQ)) u_dut_eq (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(rdy_b),
    .x_bit(x_bit), .y_bit(y_bit), .z_bit(z_bit), .en_bit(en_bit),
    .res_valid(rv[1]), .res_sat(rs[1]));
  lincon_serial_eval #(.CW(4), .C1(EC1), .C2(EC2), .K0(EK0), .REL(REL_UGT)) u_dut_ugt (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(rdy_c),
    .x_bit(x_bit), .y_bit(y_bit), .z_bit(z_bit), .en_bit(en_bit),
    .res_valid(rv[2]), .res_sat(rs[2]));

  function automatic bit rel_ref(rel_e op, longint l, longint z, int n);
    longint half = 64'sd1 <<< (n - 1);
    longint sl   = (l >= half) ? l - (half <<< 1) : l;
    longint sz   = (z >= half) ? z - (half <<< 1) : z;
    case (op)
      REL_EQ:  return l == z;
      REL_NE:  return l != z;
      REL_ULT: return l < z;
      REL_ULE: return l <= z;
      REL_UGT: return l > z;
      REL_UGE: return l >= z;
      REL_SLT: return sl < sz;
      REL_SLE: return sl <= sz;
      REL_SGT: return sl > sz;
      default: return sl >= sz;
    endcase
  endfunction

  function automatic bit sat_ref(rel_e op, longint x, longint y, longint z, int n, bit en);
    longint m = (64'sd1 <<< n) - 1;
    longint l = (EC1 * x + EC2 * y + EK0) & m;
    return en && (n >= EKMIN) && rel_ref(op, l, z & m, n);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_beat(string req, longint x, longint y, longint z, int n, bit en);
    rel_e ops[3] = '{REL_SLE, REL_EQ, REL_UGT};
    check("R1", rv[0], 1'b1);
    for (int k = 0; k < 3; k++) check(req, rs[k], sat_ref(ops[k], x, y, z, n, en));
  endtask

  // drive one beat at the falling edge; the result is visible one edge later
  task automatic beat(bit st, bit xb, bit yb, bit zb, bit eb);
    start = st; in_valid = 1'b1; x_bit = xb; y_bit = yb; z_bit = zb; en_bit = eb;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
  endtask

  task automatic run_vec(string req, longint x, longint y, longint z, int n,
                         bit en_st, bit en_rest, int gap_at);
    for (int i = 0; i < n; i++) begin
      beat(i == 0, x[i], y[i], z[i], (i == 0) ? en_st : en_rest);
      check_beat(req, x, y, z, i + 1, en_st);
      if (i == gap_at) begin
        logic [2:0] hold = rs;
        x_bit = ~x_bit; z_bit = ~z_bit; en_bit = ~en_bit; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8", rv[0] | rv[1] | rv[2], 1'b0);
        for (int k = 0; k < 3; k++) check("R8", rs[k], hold[k]);
      end
    end
  endtask

  task automatic t_reset;
    check("R10", rv[0] | rv[1] | rv[2], 1'b0);
    check("R10", rs[0] | rs[1] | rs[2], 1'b0);
    check("R9", rdy_a & rdy_b & rdy_c, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", rv[0] | rs[0], 1'b0);
    check("R9", rdy_a, 1'b1);
  endtask

  task automatic t_guard;     // EQ holds from bit 0, masked for 3 beats
    run_vec("R5", 0, 0, -6, 8, 1'b1, 1'b1, -1);
    run_vec("R5", 2, 0, 0, 6, 1'b1, 1'b1, -1);
  endtask

  task automatic t_const;     // sign of K0 extended past CW
    run_vec("R3", 0, 0, -6, 16, 1'b1, 1'b1, -1);
    run_vec("R3", 2, 0, 0, 16, 1'b1, 1'b1, -1);
  endtask

  task automatic t_enable;
    run_vec("R6", 0, 0, -6, 10, 1'b0, 1'b1, -1);
    run_vec("R6", 0, 0, -6, 10, 1'b1, 1'b0, -1);
  endtask

  task automatic t_stall;
    run_vec("R8", 0, 0, -6, 9, 1'b1, 1'b1, 5);
    run_vec("R8", 37, 11, 500, 12, 1'b1, 1'b1, 1);
  endtask

  task automatic t_restart;   // abandoned streams must leave no trace
    run_vec("R7", 16'hffff, 0, 0, 5, 1'b1, 1'b1, -1);
    run_vec("R7", 0, 0, -6, 8, 1'b1, 1'b1, -1);
    run_vec("R7", 16'h7777, 16'h1234, 3, 3, 1'b1, 1'b1, -1);
    run_vec("R7", 5, 7, -5, 8, 1'b1, 1'b1, -1);
  endtask

  task automatic t_arith;     // carries through every delay stage
    run_vec("R2", 16'hffff, 16'hffff, 0, 16, 1'b1, 1'b1, -1);
    run_vec("R2", 16'h5555, 16'haaaa, 16'h8000, 16, 1'b1, 1'b1, -1);
    run_vec("R4", 100, 50, 194, 16, 1'b1, 1'b1, -1);
  endtask

  task automatic t_random;
    for (int v = 0; v < 60; v++) begin
      longint x = longint'($urandom_range(0, 65535));
      longint y = longint'($urandom_range(0, 65535));
      longint z = (v % 3 == 0) ? ((EC1 * x + EC2 * y + EK0) & 16'hffff)
                               : longint'($urandom_range(0, 65535));
      run_vec("R4", x, y, z, 16, 1'b1, 1'b1, (v % 7 == 0) ? 3 : -1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_guard();
    t_const();
    t_enable();
    t_stall();
    t_restart();
    t_arith();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule